// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves data between memory and I/O devices for four independent channels while the processor stays off the bus. Each channel holds a current address and a current count, base copies of both, a mode, a mask bit, a software request bit and a terminal-count flag. When an unmasked channel has a pending request, the block raises a bus hold request. Once the processor grants the bus, the block serves the winning channel one transfer per clock. During each transfer it drives the address, one memory strobe and one I/O strobe, and it acknowledges the device.

After each transfer the channel's address steps up or down by one and its count steps down by one. The mode decides when service ends. Single mode ends after one transfer per grant. Block mode ends on terminal count. Demand mode also ends when the device drops its request. In every mode an external end-of-process input ends service early. When auto-initialize is set, terminal count reloads the channel from its base copies. Software programs the channels through a one-cycle register write port and reads the terminal-count flags, which clear when they are read.

Top module: `dmac_core`

## Requirements
- R1: After reset, hold_req is 0, dack is all zero, the four strobes are 1 (inactive), addr is 0 and stat_tc is 0. Every mask bit, software request bit and mode is 0.
- R2: A write (wr_en=1) with wr_sel=0 loads both the base and the current address of channel wr_ch. wr_sel=1 does the same for the count. wr_sel=2 loads the mode from wr_data[4:0]: bits [1:0] are the kind (0 demand, 1 single, 2 block, 3 acts as single), bit 2 is direction, bit 3 is decrement and bit 4 is auto-initialize. wr_sel=3 with wr_ch=0 loads the mask bits from wr_data[3:0], and wr_sel=3 with wr_ch=1 loads the software request bits from wr_data[3:0]. Bit i of these belongs to channel i.
- R3: An unmasked request raises hold_req on the next clock. No acknowledge or strobe is driven until hold_ack has been seen high, and hold_req returns to 0 in the cycle after the last transfer of a service.
- R4: At grant, the lowest-numbered pending channel wins. At most one dack bit is high, and it is the bit of the channel being served. A channel in block or demand service keeps the bus until its stop condition.
- R5: Each transfer lasts one clock and presents the current address on addr. Afterwards the address rises by 1, or falls by 1 when the decrement bit is set, and the count falls by 1.
- R6: With direction=1 a transfer drives io_rd_n=0 and mem_wr_n=0 (device to memory). With direction=0 it drives mem_rd_n=0 and io_wr_n=0 (memory to device). The other two strobes stay 1.
- R7: A transfer made while the count is 0 is the terminal one: term_cnt is 1 during it, and the count becomes FFFFh unless auto-initialize applies. That channel's stat_tc bit is then set, and a stat_rd pulse clears it on the next clock.
- R8: In single mode, each grant yields exactly one transfer, and hold_req drops between transfers.
- R9: In block mode, transfers continue under one hold until terminal count, whether or not the device request stays high.
- R10: In demand mode, service ends after the transfer during which the device request is low, or on terminal count.
- R11: eop_n=0 during a transfer makes it the last of the service in any mode. It sets no stat_tc bit.
- R12: A channel whose mask bit is 1 neither raises hold_req nor receives dack. Clearing the mask lets its pending request be served.
- R13: A software request bit starts service with no device request. It is cleared by that channel's terminal count or by end-of-process.
- R14: With auto-initialize set, the terminal transfer reloads the current address and count from the base copies, so the next service repeats the programmed addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register kind to write |
| wr_ch | input | 2 | Channel or global sub-select |
| wr_data | input | 16 | Write data |
| stat_rd | input | 1 | Status read; clears the terminal-count flags |
| stat_tc | output | 4 | Per-channel terminal-count flags |
| dreq | input | 4 | Device requests, active high |
| dack | output | 4 | Device acknowledges, active high |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| eop_n | input | 1 | External end of process, active low |
| addr | output | 16 | Transfer address |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| term_cnt | output | 1 | High during a terminal transfer |

## Verification
The bench builds the block with its default parameters: four channels with 16-bit address and count. Because of this, small programmed counts reach terminal count within a few transfers, and the priority, mask and software request behaviour can be exercised on all four channels. A bus-owner model returns hold_ack one cycle after hold_req. A device model drops each request, or pulls end-of-process low, after a chosen number of acknowledges. This makes the stopping point in demand, block and end-of-process service exact and checkable.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
   typedef enum logic [1:0] {
      XK_DEMAND = 2'b00,
      XK_SINGLE = 2'b01,
      XK_BLOCK  = 2'b10,
      XK_RSVD   = 2'b11
   } xkind_t;

   typedef struct packed {
      logic   autoinit;
      logic   dec;
      logic   to_mem;
      xkind_t kind;
   } chmode_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_WAIT = 2'b01,
      SQ_XFER = 2'b10
   } sq_t;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_MODE = 2'd2;
   localparam logic [1:0] SEL_GLOB = 2'd3;
endpackage

// File: rtl/dmac_chan.sv
`timescale 1ns/1ps
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [DW-1:0] cfg_data,
   input  logic          mask_we,
   input  logic          mask_d,
   input  logic          req_we,
   input  logic          req_d,
   input  logic          step,
   input  logic          eop,
   input  logic          stat_clr,
   output logic [AW-1:0] cur_addr,
   output chmode_t       mode,
   output logic          at_tc,
   output logic          masked,
   output logic          swreq,
   output logic          tc_flag
);
   logic [AW-1:0] base_addr;
   logic [CW-1:0] base_cnt, cur_cnt;
   logic          reload;

   assign at_tc  = (cur_cnt == '0);
   assign reload = at_tc && mode.autoinit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_addr <= '0;
         cur_addr  <= '0;
         base_cnt  <= '0;
         cur_cnt   <= '0;
         mode      <= '0;
      end else begin
         if (cfg_we && cfg_sel == SEL_ADDR) begin
            base_addr <= cfg_data[AW-1:0];
            cur_addr  <= cfg_data[AW-1:0];
         end else if (step) begin
            if (reload)        cur_addr <= base_addr;
            else if (mode.dec) cur_addr <= cur_addr - 1'b1;
            else               cur_addr <= cur_addr + 1'b1;
         end
         if (cfg_we && cfg_sel == SEL_CNT) begin
            base_cnt <= cfg_data[CW-1:0];
            cur_cnt  <= cfg_data[CW-1:0];
         end else if (step) begin
            cur_cnt <= reload ? base_cnt : cur_cnt - 1'b1;
         end
         if (cfg_we && cfg_sel == SEL_MODE)
            mode <= chmode_t'(cfg_data[4:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         masked  <= 1'b0;
         swreq   <= 1'b0;
         tc_flag <= 1'b0;
      end else begin
         if (mask_we) masked <= mask_d;
         if (req_we)                      swreq <= req_d;
         else if (step && (at_tc || eop)) swreq <= 1'b0;
         if (step && at_tc)  tc_flag <= 1'b1;
         else if (stat_clr)  tc_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/dmac_prio.sv
`timescale 1ns/1ps
module dmac_prio #(
   parameter int NCH = 4,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] win
);
   always_comb begin
      win = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) win = CHW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
module dmac_seq
   import dmac_pkg::*;
#(
   parameter int CHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pend_any,
   input  logic [CHW-1:0] win,
   input  logic           hold_ack,
   input  logic           eop_n,
   input  xkind_t         act_kind,
   input  logic           act_tc,
   input  logic           act_req,
   output logic           hold_req,
   output logic           xfer,
   output logic [CHW-1:0] act_ch
);
   sq_t  st;
   logic stop;

   always_comb begin
      unique case (act_kind)
         XK_BLOCK:  stop = act_tc || !eop_n;
         XK_DEMAND: stop = act_tc || !eop_n || !act_req;
         default:   stop = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         act_ch <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: if (pend_any) st <= SQ_WAIT;
            SQ_WAIT: if (hold_ack) begin
               if (pend_any) begin
                  act_ch <= win;
                  st     <= SQ_XFER;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            SQ_XFER: if (stop) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign hold_req = (st != SQ_IDLE);
   assign xfer     = (st == SQ_XFER);
endmodule

// File: rtl/dmac_core.sv
`timescale 1ns/1ps
module dmac_core
   import dmac_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int CW  = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int DW  = (AW > CW) ? AW : CW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_sel,
   input  logic [CHW-1:0] wr_ch,
   input  logic [DW-1:0]  wr_data,
   input  logic           stat_rd,
   output logic [NCH-1:0] stat_tc,
   input  logic [NCH-1:0] dreq,
   output logic [NCH-1:0] dack,
   output logic           hold_req,
   input  logic           hold_ack,
   input  logic           eop_n,
   output logic [AW-1:0]  addr,
   output logic           mem_rd_n,
   output logic           mem_wr_n,
   output logic           io_rd_n,
   output logic           io_wr_n,
   output logic           term_cnt
);
   if (NCH < 2 || NCH > DW) begin : g_bad_nch
      $error("dmac_core: NCH must lie between 2 and the data width");
   end
   if (AW < 5 || CW < 2) begin : g_bad_width
      $error("dmac_core: AW must be at least 5 and CW at least 2");
   end

   logic [AW-1:0]  ch_addr [NCH];
   chmode_t        ch_mode [NCH];
   logic [NCH-1:0] ch_tc, ch_mask, ch_sw, ch_flag, pend;
   logic           pend_any, xfer, mask_we, req_we, to_mem;
   logic [CHW-1:0] win, act_ch;

   assign mask_we = wr_en && wr_sel == SEL_GLOB && wr_ch == CHW'(0);
   assign req_we  = wr_en && wr_sel == SEL_GLOB && wr_ch == CHW'(1);
   assign pend    = (dreq | ch_sw) & ~ch_mask;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      dmac_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (wr_en && wr_sel != SEL_GLOB && wr_ch == CHW'(g)),
         .cfg_sel  (wr_sel),
         .cfg_data (wr_data),
         .mask_we  (mask_we),
         .mask_d   (wr_data[g]),
         .req_we   (req_we),
         .req_d    (wr_data[g]),
         .step     (xfer && act_ch == CHW'(g)),
         .eop      (!eop_n),
         .stat_clr (stat_rd),
         .cur_addr (ch_addr[g]),
         .mode     (ch_mode[g]),
         .at_tc    (ch_tc[g]),
         .masked   (ch_mask[g]),
         .swreq    (ch_sw[g]),
         .tc_flag  (ch_flag[g])
      );
   end

   dmac_prio #(.NCH(NCH)) u_prio (
      .req (pend),
      .any (pend_any),
      .win (win)
   );

   dmac_seq #(.CHW(CHW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_any (pend_any),
      .win      (win),
      .hold_ack (hold_ack),
      .eop_n    (eop_n),
      .act_kind (ch_mode[act_ch].kind),
      .act_tc   (ch_tc[act_ch]),
      .act_req  (dreq[act_ch] | ch_sw[act_ch]),
      .hold_req (hold_req),
      .xfer     (xfer),
      .act_ch   (act_ch)
   );

   assign to_mem   = ch_mode[act_ch].to_mem;
   assign dack     = xfer ? (NCH'(1) << act_ch) : '0;
   assign addr     = xfer ? ch_addr[act_ch] : '0;
   assign mem_rd_n = !(xfer && !to_mem);
   assign io_wr_n  = !(xfer && !to_mem);
   assign io_rd_n  = !(xfer && to_mem);
   assign mem_wr_n = !(xfer && to_mem);
   assign term_cnt = xfer && ch_tc[act_ch];
   assign stat_tc  = ch_flag;
endmodule

// File: rtl/dmac_core_chk.sv
`timescale 1ns/1ps
module dmac_core_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           hold_req,
   input logic           hold_ack,
   input logic [NCH-1:0] dack,
   input logic [NCH-1:0] mask,
   input logic [NCH-1:0] stat_tc,
   input logic           term_cnt,
   input logic           mem_rd_n,
   input logic           mem_wr_n,
   input logic           io_rd_n,
   input logic           io_wr_n
);
   AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack)); // R4
   AST_DACK_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> (hold_req && hold_ack)); // R3
   AST_HOLD_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_req) |-> (dack == '0)); // R3
   AST_DACK_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ((dack & mask) == '0)); // R12
   AST_STROBE_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n) |-> (|dack)); // R6
   AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ((!mem_rd_n && !io_wr_n && mem_wr_n && io_rd_n) ||
                   (!mem_wr_n && !io_rd_n && mem_rd_n && io_wr_n))); // R6
   AST_TC_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      term_cnt |-> (|dack)); // R7
   AST_TC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      term_cnt |=> ((stat_tc & $past(dack)) != '0)); // R7
endmodule

bind dmac_core dmac_core_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_req (hold_req),
   .hold_ack (hold_ack),
   .dack     (dack),
   .mask     (ch_mask),
   .stat_tc  (stat_tc),
   .term_cnt (term_cnt),
   .mem_rd_n (mem_rd_n),
   .mem_wr_n (mem_wr_n),
   .io_rd_n  (io_rd_n),
   .io_wr_n  (io_wr_n)
);

// File: tb/dmac_core_test.sv
`timescale 1ns/1ps
module dmac_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [1:0]  wr_ch = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        stat_rd = 1'b0;
   logic [3:0]  stat_tc;
   logic [3:0]  dreq = 4'd0;
   logic [3:0]  dack;
   logic        hold_req;
   logic        hold_ack = 1'b0;
   logic        eop_n = 1'b1;
   logic [15:0] addr;
   logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, term_cnt;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dmac_core uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
      .wr_data(wr_data), .stat_rd(stat_rd), .stat_tc(stat_tc), .dreq(dreq),
      .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack), .eop_n(eop_n),
      .addr(addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
      .io_wr_n(io_wr_n), .term_cnt(term_cnt)
   );

   // bus owner: grants one cycle after the request
   always @(posedge clk) hold_ack <= hold_req;

   // transfer log and device model, sampled on the falling edge
   int          nlog = 0;
   int          hold_rises = 0;
   logic        prev_hold = 1'b0;
   int          lg_ch   [16];
   logic [15:0] lg_addr [16];
   logic        lg_tc   [16];
   logic        lg_tomem[16];
   logic        lg_frmem[16];
   int          drop_after [4];
   int          seen [4];
   int          eop_after = 0;

   always @(negedge clk) begin
      if (hold_req && !prev_hold) hold_rises++;
      prev_hold = hold_req;
      if (dack != 4'd0) begin
         for (int c = 0; c < 4; c++) begin
            if (dack[c]) begin
               if (nlog < 16) begin
                  lg_ch[nlog]    = c;
                  lg_addr[nlog]  = addr;
                  lg_tc[nlog]    = term_cnt;
                  lg_tomem[nlog] = !io_rd_n && !mem_wr_n && mem_rd_n && io_wr_n;
                  lg_frmem[nlog] = !mem_rd_n && !io_wr_n && mem_wr_n && io_rd_n;
               end
               seen[c]++;
               if (seen[c] == drop_after[c]) dreq[c] = 1'b0;
            end
         end
         nlog++;
         if (nlog == eop_after) eop_n = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [1:0] ch, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_ch = ch; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clear_log();
      @(negedge clk);
      nlog = 0; hold_rises = 0; eop_after = 0;
      for (int c = 0; c < 4; c++) begin
         seen[c] = 0; drop_after[c] = 0;
      end
   endtask

   task automatic settle(); repeat (40) @(negedge clk); endtask

   task automatic read_status();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk_eq("R1 hold_req", hold_req, 0);
      chk_eq("R1 dack", dack, 0);
      chk_eq("R1 strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
      chk_eq("R1 addr", addr, 0);
      chk_eq("R1 stat_tc", stat_tc, 0);
   endtask

   task automatic t_single();
      wreg(2'd0, 2'd1, 16'h2000);
      wreg(2'd1, 2'd1, 16'd2);
      wreg(2'd2, 2'd1, 16'h0005);   // single, device to memory, increment
      clear_log();
      drop_after[1] = 3;
      dreq[1] = 1'b1;
      settle();
      chk_eq("R8 single transfer count", nlog, 3);
      chk_eq("R8 one hold per transfer", hold_rises, 3);
      for (int k = 0; k < 3; k++) begin
         chk_eq("R4 single channel", lg_ch[k], 1);
         chk_eq("R2 R5 single address", lg_addr[k], 16'h2000 + k);
         chk_eq("R6 device to memory strobes", lg_tomem[k], 1);
         chk_eq("R7 single term_cnt", lg_tc[k], (k == 2) ? 1 : 0);
      end
      chk_eq("R7 status after tc", stat_tc, 4'b0010);
      read_status();
      chk_eq("R7 status cleared by read", stat_tc, 4'b0000);
   endtask

   task automatic t_block();
      wreg(2'd0, 2'd0, 16'h1000);
      wreg(2'd1, 2'd0, 16'd4);
      wreg(2'd2, 2'd0, 16'h000A);   // block, memory to device, decrement
      clear_log();
      drop_after[0] = 1;
      dreq[0] = 1'b1;
      settle();
      chk_eq("R9 block transfer count", nlog, 5);
      chk_eq("R9 block single hold", hold_rises, 1);
      for (int k = 0; k < 5; k++) begin
         chk_eq("R5 decrement address", lg_addr[k], 16'h1000 - k);
         chk_eq("R6 memory to device strobes", lg_frmem[k], 1);
      end
      chk_eq("R7 block tc last", lg_tc[4], 1);
      chk_eq("R7 block tc not early", lg_tc[3], 0);
      chk_eq("R7 block status", stat_tc, 4'b0001);
      read_status();
   endtask

   task automatic t_demand();
      wreg(2'd0, 2'd2, 16'h0400);
      wreg(2'd1, 2'd2, 16'd100);
      wreg(2'd2, 2'd2, 16'h0000);   // demand, memory to device, increment
      clear_log();
      drop_after[2] = 3;
      dreq[2] = 1'b1;
      settle();
      chk_eq("R10 demand stops on request drop", nlog, 3);
      chk_eq("R10 demand one hold", hold_rises, 1);
      chk_eq("R10 demand last address", lg_addr[2], 16'h0402);
      chk_eq("R10 demand no status", stat_tc, 4'b0000);
   endtask

   task automatic t_eop();
      wreg(2'd0, 2'd3, 16'h5000);
      wreg(2'd1, 2'd3, 16'd10);
      wreg(2'd2, 2'd3, 16'h0002);   // block, memory to device, increment
      clear_log();
      eop_after = 2;
      wreg(2'd3, 2'd1, 16'h0008);   // software request for channel 3
      settle();
      chk_eq("R13 software start channel", lg_ch[0], 3);
      chk_eq("R11 eop ends block", nlog, 2);
      chk_eq("R11 eop no tc output", lg_tc[1], 0);
      chk_eq("R11 eop no status", stat_tc, 4'b0000);
      eop_n = 1'b1;
      settle();
      chk_eq("R13 software request cleared by eop", nlog, 2);
   endtask

   task automatic t_prio();
      wreg(2'd0, 2'd0, 16'h0100);
      wreg(2'd1, 2'd0, 16'd0);
      wreg(2'd2, 2'd0, 16'h0001);
      wreg(2'd0, 2'd3, 16'h0300);
      wreg(2'd1, 2'd3, 16'd0);
      wreg(2'd2, 2'd3, 16'h0001);
      clear_log();
      drop_after[0] = 1;
      drop_after[3] = 1;
      dreq[0] = 1'b1;
      dreq[3] = 1'b1;
      settle();
      chk_eq("R4 two transfers", nlog, 2);
      chk_eq("R4 channel 0 first", lg_ch[0], 0);
      chk_eq("R4 channel 3 second", lg_ch[1], 3);
      chk_eq("R4 second address", lg_addr[1], 16'h0300);
      chk_eq("R7 both flags", stat_tc, 4'b1001);
      read_status();
   endtask

   task automatic t_mask();
      wreg(2'd3, 2'd0, 16'h0004);   // mask channel 2
      wreg(2'd0, 2'd2, 16'h0700);
      wreg(2'd1, 2'd2, 16'd0);
      wreg(2'd2, 2'd2, 16'h0001);
      clear_log();
      drop_after[2] = 1;
      dreq[2] = 1'b1;
      settle();
      chk_eq("R12 masked no transfer", nlog, 0);
      chk_eq("R12 masked no hold", hold_rises, 0);
      wreg(2'd3, 2'd0, 16'h0000);
      settle();
      chk_eq("R12 unmasked served", nlog, 1);
      chk_eq("R12 unmasked address", lg_addr[0], 16'h0700);
      read_status();
   endtask

   task automatic t_auto();
      wreg(2'd0, 2'd1, 16'h3000);
      wreg(2'd1, 2'd1, 16'd1);
      wreg(2'd2, 2'd1, 16'h0016);   // block, device to memory, increment, auto-init
      clear_log();
      wreg(2'd3, 2'd1, 16'h0002);
      settle();
      chk_eq("R13 software block count", nlog, 2);
      wreg(2'd3, 2'd1, 16'h0002);
      settle();
      chk_eq("R14 second service count", nlog, 4);
      chk_eq("R14 reload address first", lg_addr[2], 16'h3000);
      chk_eq("R14 reload address second", lg_addr[3], 16'h3001);
      chk_eq("R14 tc again", lg_tc[3], 1);
      chk_eq("R7 auto status", stat_tc, 4'b0010);
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 4; c++) begin
         drop_after[c] = 0; seen[c] = 0;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_single();
      t_block();
      t_demand();
      t_eop();
      t_prio();
      t_mask();
      t_auto();
      report();
   end

   initial begin
      #750000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end
endmodule